// File: doc/BRIEF.md
# Serial CRC-32 Datapath Sequencer

This block is the controller for an external CRC-32 datapath that has no control logic of its own and is reached only through a few control pins. The datapath holds an 8-bit byte register, a 32-bit lookup register loaded one bit at a time, and a 32-bit CRC register. The CRC register can either shift serially or take a parallel load of `(crc >> 8) ^ entry`. The datapath flip-flops change on the falling clock edge. Their reset is asynchronous and active low, and it sets every bit to one, so the running CRC starts at 0xFFFFFFFF. The datapath also inverts its serial CRC output, which supplies the final XOR with all ones.

The sequencer takes a byte stream through a valid/ready handshake that carries a last flag. For each byte it performs these steps in order:

1. It writes the byte into the datapath.
2. It reads the 8-bit table index that the datapath forms.
3. It requests the 32-bit table entry on a request/response port.
4. It shifts that entry into the lookup register, most significant bit first.
5. It commits the update with a single parallel-load cycle.

After the last byte it shifts the CRC register out, most significant bit first, and collects the bits into a 32-bit word. It reports that word with a one-cycle done pulse. It then stays in the readout state until the next reset. All controller outputs are registers that change on the rising edge, so they are settled at every falling edge, where the datapath samples.

Top module: `crc_serial_seq`

## Requirements
- R1: While `rst` is high, `in_ready`, `tbl_req`, `dp_byte_we`, `dp_lut_we`, `dp_crc_we`, `dp_crc_par` and `crc_done` are all low. From the first clock of reset, `dp_rst_n` is low. In the second cycle after `rst` falls, `in_ready` is high.
- R2: A byte is taken on a clock where `in_valid` and `in_ready` are both high. It then appears on `dp_byte` with `dp_byte_we` high for exactly one cycle. `in_ready` stays low from that clock until the update for that byte has been committed.
- R3: One cycle after the byte write, `tbl_req` rises with `tbl_addr` equal to `dp_addr`, which is the byte XOR bits 7:0 of the running CRC. `tbl_req` and `tbl_addr` stay unchanged until a clock on which `tbl_rsp_valid` is high.
- R4: A `tbl_rsp_valid` strobe that arrives while no request is pending has no effect on the sequence or on the resulting CRC.
- R5: The accepted table word is presented on `dp_lut_bit`, bit 31 first and bit 0 last. During this transfer `dp_lut_we` is high for exactly 32 consecutive cycles.
- R6: After the transfer, `dp_crc_par` and `dp_crc_we` are high together for exactly one cycle, and `dp_lut_we` is low in that cycle. There is one such load per byte.
- R7: After the load for a byte marked last, `dp_crc_we` stays high with `dp_crc_par` low while 32 bits of `dp_crc_ser` are captured, the first bit into bit 31. The word appears on `crc_result` with a one-cycle `crc_done` pulse. For the ASCII input "123456789" the result is 0xCBF43926.
- R8: After `crc_done`, the block does not raise `in_ready`, `tbl_req` or `crc_done` again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; controller acts on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | DATA_W | Message byte |
| in_last | input | 1 | Marks the final byte of the message |
| tbl_req | output | 1 | Table entry request, held until the response |
| tbl_addr | output | DATA_W | Table index for the request |
| tbl_rsp_valid | input | 1 | Table response strobe |
| tbl_rsp_word | input | CRC_W | Table entry |
| dp_rst_n | output | 1 | Active-low reset to the datapath |
| dp_byte | output | DATA_W | Byte to the datapath byte register |
| dp_byte_we | output | 1 | Byte register write enable |
| dp_addr | input | DATA_W | Table index formed by the datapath |
| dp_lut_bit | output | 1 | Serial input of the lookup register |
| dp_lut_we | output | 1 | Lookup register shift enable |
| dp_crc_bit | output | 1 | Serial input of the CRC register |
| dp_crc_par | output | 1 | CRC register parallel-load select |
| dp_crc_we | output | 1 | CRC register write enable |
| dp_crc_ser | input | 1 | Inverted serial output of the CRC register |
| crc_result | output | CRC_W | Collected CRC word |
| crc_done | output | 1 | One-cycle pulse when `crc_result` is valid |

## Verification
The bench builds the block with its default parameters, DATA_W = 8 and CRC_W = 32. Only these values match a real CRC-32 datapath, which the bench models at falling-edge timing. With them, every result can be compared with a computed reference CRC, including the known check value for "123456789". Single-byte messages of 0x00 and 0xFF exercise the shortest path through the sequence. Random table latency, stray table strobes and input stalls cover the handshakes.

// File: rtl/crc_seq_pkg.sv
package crc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE,
    ST_TABLE,
    ST_COMMIT,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/crc_seq_req.sv
// Holds a table request and its index until a response strobe arrives.
module crc_seq_req #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rsp_valid_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          got_o
);
  assign got_o = req_o && rsp_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      addr_o <= '0;
    end else if (got_o) begin
      req_o <= 1'b0;
    end else if (issue_i) begin
      req_o  <= 1'b1;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/crc_seq_ser.sv
// Parallel-to-serial stage: presents a word MSB first, one bit per cycle.
module crc_seq_ser #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_i,
  output logic         bit_o,
  output logic         en_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] left_q;

  assign last_o = en_o && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      en_o   <= 1'b0;
      bit_o  <= 1'b0;
    end else if (load) begin
      bit_o  <= word_i[W-1];
      sh_q   <= {word_i[W-2:0], 1'b0};
      left_q <= CW'(W - 1);
      en_o   <= 1'b1;
    end else if (en_o) begin
      if (left_q != '0) begin
        bit_o  <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end else begin
        en_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc_seq_deser.sv
// Serial-to-parallel stage: collects W bits, first bit into the MSB.
module crc_seq_deser #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bit_i,
  output logic         busy_o,
  output logic [W-1:0] word_o,
  output logic         done_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  acc_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      left_q <= '0;
      busy_o <= 1'b0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        acc_q  <= {{(W-1){1'b0}}, bit_i};
        left_q <= CW'(W - 1);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        acc_q  <= {acc_q[W-2:0], bit_i};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy_o <= 1'b0;
          word_o <= {acc_q[W-2:0], bit_i};
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc_serial_seq.sv
module crc_serial_seq #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              tbl_req,
  output logic [DATA_W-1:0] tbl_addr,
  input  logic              tbl_rsp_valid,
  input  logic [CRC_W-1:0]  tbl_rsp_word,
  output logic              dp_rst_n,
  output logic [DATA_W-1:0] dp_byte,
  output logic              dp_byte_we,
  input  logic [DATA_W-1:0] dp_addr,
  output logic              dp_lut_bit,
  output logic              dp_lut_we,
  output logic              dp_crc_bit,
  output logic              dp_crc_par,
  output logic              dp_crc_we,
  input  logic              dp_crc_ser,
  output logic [CRC_W-1:0]  crc_result,
  output logic              crc_done
);
  import crc_seq_pkg::*;

  seq_state_e state_q;
  logic       wrote_q;
  logic       last_q;
  logic       par_q;
  logic       rstn_q;
  logic       issue;
  logic       got;
  logic       ser_last;
  logic       drain_start;
  logic       drain_busy;

  assign in_ready    = (state_q == ST_BYTE) && !wrote_q;
  assign issue       = (state_q == ST_BYTE) && wrote_q;
  assign drain_start = (state_q == ST_COMMIT) && last_q;
  assign dp_rst_n    = rstn_q;
  assign dp_crc_par  = par_q;
  assign dp_crc_we   = par_q | drain_busy;
  assign dp_crc_bit  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      wrote_q    <= 1'b0;
      last_q     <= 1'b0;
      par_q      <= 1'b0;
      rstn_q     <= 1'b0;
      dp_byte    <= '0;
      dp_byte_we <= 1'b0;
    end else begin
      rstn_q     <= 1'b1;
      dp_byte_we <= 1'b0;
      par_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: state_q <= ST_BYTE;
        ST_BYTE: begin
          if (!wrote_q) begin
            if (in_valid) begin
              dp_byte    <= in_data;
              last_q     <= in_last;
              dp_byte_we <= 1'b1;
              wrote_q    <= 1'b1;
            end
          end else begin
            wrote_q <= 1'b0;
            state_q <= ST_TABLE;
          end
        end
        ST_TABLE: begin
          if (ser_last) begin
            par_q   <= 1'b1;
            state_q <= ST_COMMIT;
          end
        end
        ST_COMMIT: state_q <= last_q ? ST_DRAIN : ST_BYTE;
        ST_DRAIN:  state_q <= ST_DRAIN;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  crc_seq_req #(.AW(DATA_W)) u_req (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue),
    .addr_i      (dp_addr),
    .rsp_valid_i (tbl_rsp_valid),
    .req_o       (tbl_req),
    .addr_o      (tbl_addr),
    .got_o       (got)
  );

  crc_seq_ser #(.W(CRC_W)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .load   (got),
    .word_i (tbl_rsp_word),
    .bit_o  (dp_lut_bit),
    .en_o   (dp_lut_we),
    .last_o (ser_last)
  );

  crc_seq_deser #(.W(CRC_W)) u_deser (
    .clk    (clk),
    .rst    (rst),
    .start  (drain_start),
    .bit_i  (dp_crc_ser),
    .busy_o (drain_busy),
    .word_o (crc_result),
    .done_o (crc_done)
  );
endmodule

// File: rtl/crc_seq_checker.sv
module crc_seq_checker #(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              tbl_req,
  input logic [DATA_W-1:0] tbl_addr,
  input logic              tbl_rsp_valid,
  input logic              dp_byte_we,
  input logic              dp_lut_we,
  input logic              dp_crc_par,
  input logic              dp_crc_we,
  input logic              crc_done
);
  localparam int RW = $clog2(CRC_W) + 2;

  logic [RW-1:0] run_q;
  logic          done_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      done_seen_q <= 1'b0;
    end else begin
      run_q <= dp_lut_we ? run_q + 1'b1 : '0;
      if (crc_done) done_seen_q <= 1'b1;
    end
  end

  AST_BYTE_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dp_byte_we |=> !dp_byte_we); // R2
  AST_NO_READY_WHILE_WRITE: assert property (@(posedge clk) disable iff (rst)
    dp_byte_we |-> !in_ready); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (tbl_req && !tbl_rsp_valid) |=> (tbl_req && $stable(tbl_addr))); // R3
  AST_LUT_RUN_32: assert property (@(posedge clk) disable iff (rst)
    $fell(dp_lut_we) |-> (run_q == RW'(CRC_W))); // R5
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dp_crc_par |=> !dp_crc_par); // R6
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    dp_crc_par |-> (dp_crc_we && !dp_lut_we)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    crc_done |=> !crc_done); // R7
  AST_STAY_DRAINED: assert property (@(posedge clk) disable iff (rst)
    done_seen_q |-> (!in_ready && !tbl_req && !crc_done)); // R8
endmodule

bind crc_serial_seq crc_seq_checker #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_ready      (in_ready),
  .tbl_req       (tbl_req),
  .tbl_addr      (tbl_addr),
  .tbl_rsp_valid (tbl_rsp_valid),
  .dp_byte_we    (dp_byte_we),
  .dp_lut_we     (dp_lut_we),
  .dp_crc_par    (dp_crc_par),
  .dp_crc_we     (dp_crc_we),
  .crc_done      (crc_done)
);

// File: tb/crc_serial_seq_test.sv
`timescale 1ns/1ps
module crc_serial_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        tbl_req;
  logic [7:0]  tbl_addr;
  logic        tbl_rsp_valid;
  logic [31:0] tbl_rsp_word;
  logic        dp_rst_n;
  logic [7:0]  dp_byte;
  logic        dp_byte_we;
  logic [7:0]  dp_addr;
  logic        dp_lut_bit, dp_lut_we, dp_crc_bit, dp_crc_par, dp_crc_we, dp_crc_ser;
  logic [31:0] crc_result;
  logic        crc_done;

  int errors = 0;
  int checks = 0;

  logic [7:0]  msg [0:15];
  logic [31:0] run [0:15];
  int          msg_len = 0;
  int          req_idx = 0, wr_idx = 0, par_idx = 0;

  always #2 clk = ~clk;

  crc_serial_seq uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .tbl_req(tbl_req), .tbl_addr(tbl_addr),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_word(tbl_rsp_word),
    .dp_rst_n(dp_rst_n), .dp_byte(dp_byte), .dp_byte_we(dp_byte_we),
    .dp_addr(dp_addr), .dp_lut_bit(dp_lut_bit), .dp_lut_we(dp_lut_we),
    .dp_crc_bit(dp_crc_bit), .dp_crc_par(dp_crc_par), .dp_crc_we(dp_crc_we),
    .dp_crc_ser(dp_crc_ser), .crc_result(crc_result), .crc_done(crc_done)
  );

  // Falling-edge datapath model with all-ones asynchronous reset.
  logic [7:0]  m_byte;
  logic [31:0] m_lut, m_crc;
  always @(negedge clk or negedge dp_rst_n) begin
    if (!dp_rst_n) begin
      m_byte <= 8'hFF;
      m_lut  <= 32'hFFFF_FFFF;
      m_crc  <= 32'hFFFF_FFFF;
    end else begin
      if (dp_byte_we) m_byte <= dp_byte;
      if (dp_lut_we)  m_lut  <= {m_lut[30:0], dp_lut_bit};
      if (dp_crc_we)  m_crc  <= dp_crc_par ? ({8'h00, m_crc[31:8]} ^ m_lut)
                                           : {m_crc[30:0], ~dp_crc_bit};
    end
  end
  assign dp_addr    = m_byte ^ m_crc[7:0];
  assign dp_crc_ser = ~m_crc[31];

  function automatic logic [31:0] tab(input logic [7:0] idx);
    logic [31:0] c = {24'h0, idx};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return c;
  endfunction

  function automatic logic [7:0] exp_idx(input int k);
    return run[k][7:0] ^ msg[k];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Table responder with random latency and stray strobes.
  initial begin
    bit         pend = 0;
    int         lat = 0;
    logic [7:0] paddr = 0;
    tbl_rsp_valid = 0;
    tbl_rsp_word  = 0;
    forever begin
      @(negedge clk);
      tbl_rsp_valid = 0;
      if (rst) begin
        pend = 0;
      end else if (pend) begin
        chk(tbl_req && tbl_addr == paddr, "R3", {23'h0, tbl_req, tbl_addr}, {24'h1, paddr});
        if (lat == 0) begin
          tbl_rsp_valid = 1;
          tbl_rsp_word  = tab(paddr);
          pend = 0;
        end else lat--;
      end else if (tbl_req) begin
        chk(tbl_addr == exp_idx(req_idx), "R3", {24'h0, tbl_addr}, {24'h0, exp_idx(req_idx)});
        paddr = tbl_addr;
        req_idx++;
        lat  = $urandom % 4;
        pend = 1;
      end else if ($urandom % 5 == 0) begin
        tbl_rsp_valid = 1;          // stray strobe, R4
        tbl_rsp_word  = $urandom;
      end
    end
  end

  // Datapath-side monitor sampled at the falling edge.
  initial begin
    int          lut_cnt = 0;
    logic [31:0] lut_acc = 0;
    bit          prev_we = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        lut_cnt = 0; prev_we = 0;
      end else begin
        if (dp_byte_we) begin
          chk(!prev_we && dp_byte == msg[wr_idx] && !in_ready, "R2", {24'h0, dp_byte}, {24'h0, msg[wr_idx]});
          wr_idx++;
        end
        prev_we = dp_byte_we;
        if (dp_lut_we) begin
          lut_acc = {lut_acc[30:0], dp_lut_bit};
          lut_cnt++;
        end
        if (dp_crc_par) begin
          chk(lut_cnt == 32, "R5", lut_cnt, 32);
          chk(lut_acc == tab(exp_idx(par_idx)), "R5", lut_acc, tab(exp_idx(par_idx)));
          chk(dp_crc_we && !dp_lut_we, "R6", {dp_crc_we, dp_lut_we}, 2'b10);
          par_idx++;
          lut_cnt = 0;
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !tbl_req && !dp_byte_we && !dp_lut_we && !dp_crc_we && !dp_crc_par && !crc_done,
        "R1", {in_ready, tbl_req, dp_byte_we, dp_lut_we, dp_crc_we, dp_crc_par, crc_done}, 0);
    chk(dp_rst_n == 0, "R1", dp_rst_n, 0);
    req_idx = 0; wr_idx = 0; par_idx = 0;
    rst = 0;
    repeat (2) @(negedge clk);
    chk(in_ready == 1, "R1", in_ready, 1);
  endtask

  task automatic run_msg(input int stall);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] expect_crc;
    bit got = 0;
    for (int k = 0; k < msg_len; k++) begin
      run[k] = c;
      c = tab(c[7:0] ^ msg[k]) ^ (c >> 8);
    end
    expect_crc = ~c;
    do_reset();
    for (int k = 0; k < msg_len; k++) begin
      if (stall != 0) repeat ($urandom % (stall + 1)) @(negedge clk);
      in_valid = 1; in_data = msg[k]; in_last = (k == msg_len - 1);
      forever begin
        logic r = in_ready;
        @(negedge clk);
        if (r) break;
      end
      in_valid = 0;
      in_data  = $urandom;
    end
    for (int t = 0; t < 400; t++) begin
      if (crc_done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got && crc_result == expect_crc, "R7", crc_result, expect_crc);
    chk(wr_idx == msg_len && par_idx == msg_len, "R6", par_idx, msg_len);
    begin
      bit quiet = 1;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (in_ready || tbl_req || crc_done) quiet = 0;
      end
      chk(quiet, "R8", {in_ready, tbl_req, crc_done}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Check vector "123456789", R7
    for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
    msg_len = 9;
    run_msg(0);
    chk(crc_result == 32'hCBF4_3926, "R7", crc_result, 32'hCBF4_3926);
    // Single-byte corners
    msg[0] = 8'h00; msg_len = 1; run_msg(0);
    msg[0] = 8'hFF; msg_len = 1; run_msg(2);
    // Random messages with stalls, stray strobes (R4)
    for (int n = 0; n < 12; n++) begin
      msg_len = 1 + ($urandom % 16);
      for (int k = 0; k < msg_len; k++) msg[k] = $urandom;
      run_msg(n % 4);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule